// File: doc/BRIEF.md
# Linear Page Table Translator

This block maps a 32-bit virtual address onto a physical address. The lookup uses a single linear page table that is held in a local array of translation entries. Pages are 1 KB, so the ten low address bits pass through unchanged. The 22 upper bits form the virtual page number (VPN), which selects an entry directly. A supervisor places each process's table somewhere in the array. On every process switch it reloads a context made of a base slot and a table length. It reads and writes individual entries through an indexed port.

Each request is answered exactly one cycle later with a done pulse, a fault code and either a physical address or the faulting virtual address. There are three faults. A VPN at or beyond the table length is out of range. An in-range entry whose valid flag is clear is invalid. A write to an entry marked read-only is a protection fault. A translation that succeeds marks its entry as used, and a write that succeeds also marks it dirty. A fault changes no entry.

Top module: `lpt_translator`

## Requirements
- R1: After reset, `done`, `fault`, `paddr` and `fault_vaddr` are 0, every entry reads back as 0, and the table length is 0, so any request then faults as out of range.
- R2: Every cycle with `req_valid` high is answered by `done` high in the next cycle, including back-to-back requests. A cycle without a request gives `done` 0 and `fault` 0 in the next cycle.
- R3: The VPN is `req_vaddr[31:10]` and the offset is `req_vaddr[9:0]`. On success, `fault` is 0 (none) and `paddr` is the entry's 22-bit page number concatenated above the offset.
- R4: The entry used is slot (base + VPN) modulo 64. A `ctx_load` pulse loads the base and the length, and it affects requests from the next cycle onward. A loaded length above 64 is clamped to 64.
- R5: A VPN greater than or equal to the table length gives fault code 1 (range). This check takes priority over the entry's flags.
- R6: An in-range VPN whose entry has its valid flag clear gives fault code 2 (invalid).
- R7: A write request to a valid entry with its read-only flag set gives fault code 3 (read-only). A read request to the same entry succeeds.
- R8: A successful translation sets the entry's used flag. A successful write also sets its dirty flag. A successful read leaves the dirty flag unchanged.
- R9: On any fault, `fault_vaddr` equals the requested address, `paddr` is 0, and neither the used flag nor the dirty flag of any entry changes. On success, `fault_vaddr` is 0.
- R10: The entry word has valid at bit 0, read-only at bit 1, used at bit 2, dirty at bit 3, the page number at [25:4] and the stored VPN at [47:26]. `ent_rdata` shows slot `ent_idx` combinationally. An `ent_we` write replaces the whole entry, and it wins over a flag update to the same slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 32 | Virtual address to translate |
| done | output | 1 | Result valid, one cycle after the request |
| fault | output | 2 | 0 none, 1 range, 2 invalid, 3 read-only |
| paddr | output | 32 | Physical address on success, else 0 |
| fault_vaddr | output | 32 | Faulting virtual address, else 0 |
| ctx_load | input | 1 | Load a new base and length |
| ctx_base | input | 6 | First slot of the process table |
| ctx_len | input | 7 | Number of entries in the process table |
| ent_we | input | 1 | Supervisor entry write |
| ent_idx | input | 6 | Supervisor slot index |
| ent_wdata | input | 48 | Entry word to write |
| ent_rdata | output | 48 | Entry word at `ent_idx` |

## Verification
The assertions assume that the request inputs are stable across each sampling edge. They also assume that reset is applied before any request is issued. The range and offset properties compare against the table length as it stood when the request was sampled, so they assume the length register changes only through `ctx_load`. The stimulus drives all inputs on the falling edge, holds each request for exactly one rising edge, and changes the context only between checked requests or in cycles whose expected result uses the previous context.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_RANGE   = 2'd1,
      FLT_INVALID = 2'd2,
      FLT_RDONLY  = 2'd3
   } flt_e;

   // Flag nibble of an entry word: bit 0 valid, 1 read-only, 2 used, 3 dirty
   typedef struct packed {
      logic dirty;
      logic used;
      logic rdonly;
      logic valid;
   } ent_flags_t;

   localparam int FLAG_W = 4;

endpackage

// File: rtl/lpt_fault_eval.sv
module lpt_fault_eval
   import lpt_pkg::*;
#(
   parameter int VPN_W = 22,
   parameter int LEN_W = 7
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [LEN_W-1:0] tbl_len,
   input  ent_flags_t       flags,
   input  logic             is_write,
   output flt_e             code
);
   localparam int CMP_W = (VPN_W > LEN_W) ? VPN_W : LEN_W;

   logic [CMP_W-1:0] vpn_ext;
   logic [CMP_W-1:0] len_ext;

   assign vpn_ext = CMP_W'(vpn);
   assign len_ext = CMP_W'(tbl_len);

   always_comb begin
      if (vpn_ext >= len_ext)          code = FLT_RANGE;
      else if (!flags.valid)           code = FLT_INVALID;
      else if (is_write && flags.rdonly) code = FLT_RDONLY;
      else                             code = FLT_NONE;
   end
endmodule

// File: rtl/lpt_slot_map.sv
module lpt_slot_map #(
   parameter int DEPTH = 64,
   parameter int IDX_W = 6
) (
   input  logic [IDX_W-1:0] base,
   input  logic [IDX_W-1:0] vpn_low,
   output logic [IDX_W-1:0] slot
);
   localparam bit POW2 = ((1 << IDX_W) == DEPTH);

   logic [IDX_W:0] sum;
   assign sum = {1'b0, base} + {1'b0, vpn_low};

   generate
      if (POW2) begin : g_wrap_trunc
         assign slot = sum[IDX_W-1:0];
      end else begin : g_wrap_sub
         logic [IDX_W:0] wrapped;
         assign wrapped = (sum >= (IDX_W+1)'(DEPTH)) ? sum - (IDX_W+1)'(DEPTH) : sum;
         assign slot    = wrapped[IDX_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/lpt_entry_store.sv
module lpt_entry_store
   import lpt_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = 6,
   parameter int PPN_W = 22,
   parameter int TAG_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   // supervisor port
   input  logic             sv_we,
   input  logic [IDX_W-1:0] sv_idx,
   input  ent_flags_t       sv_wflags,
   input  logic [PPN_W-1:0] sv_wppn,
   input  logic [TAG_W-1:0] sv_wtag,
   output ent_flags_t       sv_rflags,
   output logic [PPN_W-1:0] sv_rppn,
   output logic [TAG_W-1:0] sv_rtag,
   // translator port
   input  logic [IDX_W-1:0] lk_idx,
   output ent_flags_t       lk_flags,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             hw_mark,
   input  logic             hw_dirty
);
   ent_flags_t       flg_q [DEPTH];
   logic [PPN_W-1:0] ppn_q [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n) begin
            flg_q[i] <= '0;
            ppn_q[i] <= '0;
            tag_q[i] <= '0;
         end else if (sv_we && (int'(sv_idx) == i)) begin
            flg_q[i] <= sv_wflags;
            ppn_q[i] <= sv_wppn;
            tag_q[i] <= sv_wtag;
         end else if (hw_mark && (int'(lk_idx) == i)) begin
            flg_q[i].used <= 1'b1;
            if (hw_dirty) flg_q[i].dirty <= 1'b1;
         end
      end
   end

   assign lk_flags  = flg_q[lk_idx];
   assign lk_ppn    = ppn_q[lk_idx];
   assign sv_rflags = flg_q[sv_idx];
   assign sv_rppn   = ppn_q[sv_idx];
   assign sv_rtag   = tag_q[sv_idx];
endmodule

// File: rtl/lpt_translator.sv
module lpt_translator
   import lpt_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int OFF_W       = 10,
   parameter int MAX_ENTRIES = 64,
   localparam int VPN_W = VA_W - OFF_W,
   localparam int PPN_W = VPN_W,
   localparam int PA_W  = PPN_W + OFF_W,
   localparam int IDX_W = $clog2(MAX_ENTRIES),
   localparam int LEN_W = IDX_W + 1,
   localparam int ENT_W = FLAG_W + PPN_W + VPN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [VA_W-1:0]  req_vaddr,
   output logic             done,
   output logic [1:0]       fault,
   output logic [PA_W-1:0]  paddr,
   output logic [VA_W-1:0]  fault_vaddr,
   input  logic             ctx_load,
   input  logic [IDX_W-1:0] ctx_base,
   input  logic [LEN_W-1:0] ctx_len,
   input  logic             ent_we,
   input  logic [IDX_W-1:0] ent_idx,
   input  logic [ENT_W-1:0] ent_wdata,
   output logic [ENT_W-1:0] ent_rdata
);
   initial begin
      if (OFF_W < 1 || OFF_W >= VA_W)
         $fatal(1, "offset width must lie inside the address");
      if (MAX_ENTRIES < 2)
         $fatal(1, "table needs at least two entries");
      if (IDX_W > VPN_W)
         $fatal(1, "table deeper than the page-number space");
   end

   // context registers
   logic [IDX_W-1:0] base_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_clamped;

   assign len_clamped = (ctx_len > LEN_W'(MAX_ENTRIES)) ? LEN_W'(MAX_ENTRIES) : ctx_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
      end else if (ctx_load) begin
         base_q <= ctx_base;
         len_q  <= len_clamped;
      end
   end

   // address split
   logic [VPN_W-1:0] req_vpn;
   logic [OFF_W-1:0] req_off;
   assign req_vpn = req_vaddr[VA_W-1:OFF_W];
   assign req_off = req_vaddr[OFF_W-1:0];

   logic [IDX_W-1:0] slot;
   lpt_slot_map #(.DEPTH(MAX_ENTRIES), .IDX_W(IDX_W)) u_map (
      .base    (base_q),
      .vpn_low (req_vpn[IDX_W-1:0]),
      .slot    (slot)
   );

   // entry array
   ent_flags_t       lk_flags, sv_rflags, sv_wflags;
   logic [PPN_W-1:0] lk_ppn, sv_rppn, sv_wppn;
   logic [VPN_W-1:0] sv_rtag, sv_wtag;
   logic             hit;

   assign sv_wflags = ent_wdata[FLAG_W-1:0];
   assign sv_wppn   = ent_wdata[FLAG_W +: PPN_W];
   assign sv_wtag   = ent_wdata[FLAG_W+PPN_W +: VPN_W];
   assign ent_rdata = {sv_rtag, sv_rppn, sv_rflags};

   lpt_entry_store #(
      .DEPTH (MAX_ENTRIES),
      .IDX_W (IDX_W),
      .PPN_W (PPN_W),
      .TAG_W (VPN_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .sv_we     (ent_we),
      .sv_idx    (ent_idx),
      .sv_wflags (sv_wflags),
      .sv_wppn   (sv_wppn),
      .sv_wtag   (sv_wtag),
      .sv_rflags (sv_rflags),
      .sv_rppn   (sv_rppn),
      .sv_rtag   (sv_rtag),
      .lk_idx    (slot),
      .lk_flags  (lk_flags),
      .lk_ppn    (lk_ppn),
      .hw_mark   (hit),
      .hw_dirty  (req_write)
   );

   // fault classification
   flt_e flt_c;
   lpt_fault_eval #(.VPN_W(VPN_W), .LEN_W(LEN_W)) u_eval (
      .vpn      (req_vpn),
      .tbl_len  (len_q),
      .flags    (lk_flags),
      .is_write (req_write),
      .code     (flt_c)
   );

   assign hit = req_valid && (flt_c == FLT_NONE);

   // result registers
   logic            done_q;
   flt_e            fault_q;
   logic [PA_W-1:0] paddr_q;
   logic [VA_W-1:0] fva_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         fault_q <= FLT_NONE;
         paddr_q <= '0;
         fva_q   <= '0;
      end else begin
         done_q  <= req_valid;
         fault_q <= req_valid ? flt_c : FLT_NONE;
         paddr_q <= hit ? {lk_ppn, req_off} : '0;
         fva_q   <= (req_valid && flt_c != FLT_NONE) ? req_vaddr : '0;
      end
   end

   assign done        = done_q;
   assign fault       = fault_q;
   assign paddr       = paddr_q;
   assign fault_vaddr = fva_q;
endmodule

// File: rtl/lpt_translator_chk.sv
module lpt_translator_chk #(
   parameter int VA_W  = 32,
   parameter int OFF_W = 10,
   parameter int PA_W  = 32,
   parameter int LEN_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [VA_W-1:0]  req_vaddr,
   input logic             done,
   input logic [1:0]       fault,
   input logic [PA_W-1:0]  paddr,
   input logic [VA_W-1:0]  fault_vaddr,
   input logic [LEN_W-1:0] len_q
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int CMP_W = (VPN_W > LEN_W) ? VPN_W : LEN_W;

   logic out_of_range;
   assign out_of_range = CMP_W'(req_vaddr[VA_W-1:OFF_W]) >= CMP_W'(len_q);

   assert_done_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!done && fault == 2'd0));

   assert_range_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && out_of_range) |=> (fault == 2'd1));

   assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !out_of_range) |=> (fault != 2'd0 ||
         paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

   assert_fault_reports_va_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (fault == 2'd0 ||
         (fault_vaddr == $past(req_vaddr) && paddr == '0)));

   assert_success_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault == 2'd0) |-> (fault_vaddr == '0));
endmodule

bind lpt_translator lpt_translator_chk #(
   .VA_W  (VA_W),
   .OFF_W (OFF_W),
   .PA_W  (PA_W),
   .LEN_W (LEN_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_vaddr   (req_vaddr),
   .done        (done),
   .fault       (fault),
   .paddr       (paddr),
   .fault_vaddr (fault_vaddr),
   .len_q       (len_q)
);

// File: tb/lpt_translator_bench.sv
`timescale 1ns/100ps
module lpt_translator_bench;
   localparam int N = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        done;
   logic [1:0]  fault;
   logic [31:0] paddr, fault_vaddr;
   logic        ctx_load = 1'b0;
   logic [5:0]  ctx_base = '0;
   logic [6:0]  ctx_len = '0;
   logic        ent_we = 1'b0;
   logic [5:0]  ent_idx = '0;
   logic [47:0] ent_wdata = '0;
   logic [47:0] ent_rdata;

   always #2.5 clk = ~clk;

   lpt_translator u_lpt_translator (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_vaddr(req_vaddr), .done(done), .fault(fault), .paddr(paddr),
      .fault_vaddr(fault_vaddr), .ctx_load(ctx_load), .ctx_base(ctx_base),
      .ctx_len(ctx_len), .ent_we(ent_we), .ent_idx(ent_idx),
      .ent_wdata(ent_wdata), .ent_rdata(ent_rdata)
   );

   // reference model
   logic [47:0] m_ent [N];
   int          m_base, m_len;
   int          n_cmp = 0, n_bad = 0;
   bit          finished = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int slot_of(input logic [21:0] vpn);
      return (m_base + int'(vpn[5:0])) % N;
   endfunction

   function automatic logic [1:0] exp_fault(input logic [31:0] va, input bit wr);
      logic [47:0] e;
      if (int'(va[31:10]) >= m_len || va[31:16] != 0) return 2'd1;
      e = m_ent[slot_of(va[31:10])];
      if (!e[0]) return 2'd2;
      if (wr && e[1]) return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic [47:0] mk_ent(input bit v, input bit ro, input bit u,
                                          input bit d, input logic [21:0] ppn,
                                          input logic [21:0] tag);
      return {tag, ppn, d, u, ro, v};
   endfunction

   task automatic sup_write(input int idx, input logic [47:0] w);
      @(negedge clk);
      ent_we = 1'b1; ent_idx = 6'(idx); ent_wdata = w;
      @(posedge clk); #1;
      ent_we = 1'b0;
      m_ent[idx] = w;
   endtask

   task automatic load_ctx(input int base, input int len);
      @(negedge clk);
      ctx_load = 1'b1; ctx_base = 6'(base); ctx_len = 7'(len);
      @(posedge clk); #1;
      ctx_load = 1'b0;
      m_base = base;
      m_len  = (len > N) ? N : len;
   endtask

   task automatic peek(input int idx, input string req);
      @(negedge clk);
      ent_idx = 6'(idx);
      #1;
      check(ent_rdata === m_ent[idx], req, 64'(ent_rdata), 64'(m_ent[idx]));
   endtask

   // request held for one rising edge; left high so calls can run back to back
   task automatic do_req(input logic [31:0] va, input bit wr, input string req);
      logic [1:0]  ef;
      logic [31:0] ep;
      int          s;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_vaddr = va;
      ef = exp_fault(va, wr);
      s  = slot_of(va[31:10]);
      ep = (ef == 2'd0) ? {m_ent[s][25:4], va[9:0]} : 32'd0;
      @(posedge clk); #1;
      check(done === 1'b1, {req, " done"}, 64'(done), 64'd1);
      check(fault === ef, {req, " fault"}, 64'(fault), 64'(ef));
      check(paddr === ep, {req, " paddr"}, 64'(paddr), 64'(ep));
      check(fault_vaddr === ((ef != 0) ? va : 32'd0), {req, " fault_vaddr"},
            64'(fault_vaddr), 64'((ef != 0) ? va : 32'd0));
      if (ef == 2'd0) begin
         m_ent[s][2] = 1'b1;
         if (wr) m_ent[s][3] = 1'b1;
      end
   endtask

   task automatic idle(input string req);
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); #1;
      check(done === 1'b0 && fault === 2'd0, req, 64'({done, fault}), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) m_ent[i] = '0;
      m_base = 0; m_len = 0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      check(done === 1'b0 && fault === 2'd0, "R1 outputs", 64'({done, fault}), 64'd0);
      check(paddr === 32'd0 && fault_vaddr === 32'd0, "R1 addresses",
            64'(paddr), 64'd0);
      peek(0, "R1 entry 0");
      peek(63, "R1 entry 63");
      do_req(32'h0000_0123, 1'b0, "R1 zero length");
      idle("R2 idle after request");

      // R10 layout and read port
      sup_write(3, mk_ent(1, 0, 0, 0, 22'h2AB3C, 22'h00007));
      peek(3, "R10 read back");
      load_ctx(0, 8);
      // R3 plain translation, R8 used set
      do_req({22'd3, 10'h1FF}, 1'b0, "R3 read hit");
      peek(3, "R8 used after read");
      check(ent_rdata[3] === 1'b0, "R8 read leaves dirty", 64'(ent_rdata[3]), 64'd0);
      do_req({22'd3, 10'h001}, 1'b1, "R8 write hit");
      peek(3, "R8 dirty after write");
      // R6 invalid
      do_req({22'd4, 10'h010}, 1'b0, "R6 invalid entry");
      // R7 read-only
      sup_write(5, mk_ent(1, 1, 0, 0, 22'h11111, 22'h5));
      do_req({22'd5, 10'h3FF}, 1'b1, "R7 write to read-only");
      peek(5, "R9 no update on fault");
      do_req({22'd5, 10'h000}, 1'b0, "R7 read of read-only");
      // R5 range boundary and priority
      sup_write(8, mk_ent(1, 0, 0, 0, 22'h0ABCD, 22'h8));
      do_req({22'd8, 10'h0}, 1'b0, "R5 vpn equals length");
      peek(8, "R9 range fault leaves entry");
      do_req({22'h3FFFFF, 10'h155}, 1'b1, "R5 huge vpn");
      // R4 clamp and wrap
      load_ctx(0, 100);
      sup_write(63, mk_ent(1, 0, 0, 0, 22'h3FFFF, 22'h3F));
      do_req({22'd63, 10'h2A}, 1'b0, "R4 clamp top entry");
      do_req({22'd64, 10'h2A}, 1'b0, "R4 clamp beyond 64");
      load_ctx(60, 10);
      sup_write(1, mk_ent(1, 0, 0, 0, 22'h1D1D1, 22'h5));
      do_req({22'd5, 10'h0C3}, 1'b1, "R4 base wraps");
      peek(1, "R4 wrapped slot marked");
      // R4 context takes effect next cycle
      @(negedge clk);
      ctx_load = 1'b1; ctx_base = 6'd0; ctx_len = 7'd2;
      req_valid = 1'b1; req_write = 1'b0; req_vaddr = {22'd5, 10'h0};
      @(posedge clk); #1;
      ctx_load = 1'b0;
      check(fault === 2'd0 && paddr === {22'h1D1D1, 10'h0}, "R4 old context used",
            64'(paddr), 64'({22'h1D1D1, 10'h0}));
      m_ent[1][2] = 1'b1;
      m_base = 0; m_len = 2;
      do_req({22'd5, 10'h0}, 1'b0, "R4 new context used");

      // R10 supervisor write wins over same-cycle flag update
      sup_write(1, mk_ent(1, 0, 0, 0, 22'h00111, 22'h1));
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_vaddr = {22'd1, 10'h7};
      ent_we = 1'b1; ent_idx = 6'd1; ent_wdata = mk_ent(1, 0, 0, 0, 22'h00222, 22'h1);
      @(posedge clk); #1;
      ent_we = 1'b0;
      check(paddr === {22'h00111, 10'h7}, "R10 lookup used old entry",
            64'(paddr), 64'({22'h00111, 10'h7}));
      m_ent[1] = mk_ent(1, 0, 0, 0, 22'h00222, 22'h1);
      peek(1, "R10 supervisor write wins");
      idle("R2 idle after conflict");

      // random phase, back to back requests
      load_ctx($urandom_range(0, 63), $urandom_range(1, 64));
      for (int i = 0; i < N; i++)
         sup_write(i, mk_ent($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
                             0, 0, 22'($urandom), 22'(i)));
      for (int k = 0; k < 400; k++) begin
         logic [31:0] va;
         va = $urandom;
         if ($urandom_range(0, 9) != 0)
            va[31:10] = 22'($urandom_range(0, m_len + 3));
         do_req(va, 1'($urandom_range(0, 1)), "R3 R5 R6 R7 random");
         if (k % 16 == 15) begin
            peek($urandom_range(0, N - 1), "R8 R9 random entry");
            idle("R2 random idle");
         end
         if (k % 50 == 49) begin
            int s;
            s = $urandom_range(0, N - 1);
            idle("R2 before clear");
            sup_write(s, {m_ent[s][47:4], 2'b00, m_ent[s][1:0]});
            peek(s, "R10 flags cleared");
         end
      end
      idle("R2 final idle");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule